// File: doc/BRIEF.md
# Serial Character Transmitter with Long Break

This block converts parallel characters into an asynchronous serial stream. A writer places a character in a one-entry holding buffer with a single-cycle strobe. The shift stage takes that character at the next bit boundary where the shift stage is free. It sends a low start bit, then the data bits with the least significant bit first, then an optional ninth bit, then a high stop bit. The bit rate comes from an external one-cycle tick, and each bit lasts from one tick to the next.

The writer can also ask for a long break instead of a character. A break holds the line low for thirteen bit-times and then sends a high stop bit. Two flags show the block's state. One says the holding buffer can take a character, and it is meant to drive an interrupt. The other says no frame is in progress. Both the module enable and the transmit enable must be high for characters to go out. When either enable is low, the line stays high.

Top module: `utx_top`

## Requirements
- R1: After reset, `txd` is high, `hold_empty` is high and `shift_idle` is high.
- R2: A `wr_stb` pulse while `hold_empty` is high stores `wr_data`, `wr_bit8`, `wr_nine` and `wr_brk`, and `hold_empty` is low from the next cycle. A `wr_stb` pulse while `hold_empty` is low is ignored, and the stored character is unchanged.
- R3: An 8-bit character (`wr_nine`=0) goes out as one low start bit, then data bits 0 to 7 in that order, then one high stop bit. Each bit starts at the clock edge where `bit_tick` is sampled high, and `txd` changes on that same edge.
- R4: A 9-bit character (`wr_nine`=1) sends `wr_bit8` after data bit 7 and before the stop bit.
- R5: A break request (`wr_brk`=1) sends 13 low bit-times (the start bit plus 12 more), then one high stop bit. The data inputs have no effect on a break.
- R6: `shift_idle` is low from the edge that loads a character until the edge that ends its stop bit with no further character to load. `txd` is high whenever `shift_idle` is high.
- R7: A stored character is loaded at a `bit_tick` edge when the shift stage is idle or sending a stop bit, provided both enables are high. `hold_empty` rises in the cycle after that edge.
- R8: If `mod_en` or `tx_en` is low, nothing is loaded, and the shift stage returns to idle at the next edge, which drives `txd` high. A stored character stays in the buffer and goes out once both enables are high again.
- R9: A character that is waiting when a stop bit ends starts with its start bit at that same edge, with no idle bit-time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable |
| tx_en | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character data bits |
| wr_bit8 | input | 1 | Ninth data bit |
| wr_nine | input | 1 | Selects 9-bit characters for this write |
| wr_brk | input | 1 | Requests a break instead of a character for this write |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding buffer can take a character (interrupt) |
| shift_idle | output | 1 | No frame in progress |

## Verification
The hardest case to reach is a buffered character meeting the last bit of the previous frame. A character must be written while another frame is still running, so that the load happens at the stop-bit boundary rather than from idle. The stimulus writes a second character a few ticks into a frame, then writes again while the buffer is still full. The other case is dropping an enable in the middle of a frame while a character is waiting in the buffer. A behavioural model built on a bit queue predicts all three outputs every cycle, so a lost gap bit, an extra gap bit, or a lost buffered character shows up as a mismatch.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              nine;
        logic              bit8;
        logic [CHAR_W-1:0] data;
    } utx_hold_t;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_START,
        TS_DATA,
        TS_BIT8,
        TS_BRK,
        TS_STOP
    } utx_state_e;

    function automatic logic utx_state_low(input utx_state_e s);
        return (s == TS_START) || (s == TS_BRK);
    endfunction

endpackage

// File: rtl/utx_hold_buf.sv
module utx_hold_buf
    import utx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  utx_hold_t wr_entry,
    input  logic      take,
    output logic      valid,
    output utx_hold_t entry
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            entry <= '0;
        end else begin
            if (take) begin
                valid <= 1'b0;
            end
            if (wr_stb && !valid) begin
                valid <= 1'b1;
                entry <= wr_entry;
            end
        end
    end

    p_write_ignored_full_r2: assert property (@(posedge clk) disable iff (rst)
        (valid && !take) |=> (valid && $stable(entry)));

    p_take_empties_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> !valid);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int BRK_EXTRA = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      tick,
    input  logic      hold_valid,
    input  utx_hold_t hold_entry,
    output logic      take,
    output logic      line,
    output logic      idle
);

    localparam int CNT_MAX = (CHAR_W > BRK_EXTRA) ? CHAR_W : BRK_EXTRA;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    utx_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [CHAR_W:0]    sh;
    logic               nine_q;
    logic               brk_q;
    logic               free;

    always_comb begin
        free = (state == TS_IDLE) || (state == TS_STOP);
        take = run && tick && hold_valid && free;
        idle = (state == TS_IDLE);
    end

    always_comb begin
        if (utx_state_low(state)) begin
            line = 1'b0;
        end else if (state == TS_DATA || state == TS_BIT8) begin
            line = sh[0];
        end else begin
            line = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TS_IDLE;
            cnt    <= '0;
            sh     <= '0;
            nine_q <= 1'b0;
            brk_q  <= 1'b0;
        end else if (!run) begin
            state <= TS_IDLE;
        end else if (tick) begin
            case (state)
                TS_IDLE, TS_STOP: begin
                    if (take) begin
                        state  <= TS_START;
                        sh     <= {hold_entry.bit8, hold_entry.data};
                        nine_q <= hold_entry.nine;
                        brk_q  <= hold_entry.brk;
                        cnt    <= '0;
                    end else begin
                        state <= TS_IDLE;
                    end
                end
                TS_START: begin
                    cnt   <= '0;
                    state <= brk_q ? TS_BRK : TS_DATA;
                end
                TS_DATA: begin
                    sh <= sh >> 1;
                    if (cnt == CNT_W'(CHAR_W - 1)) begin
                        cnt   <= '0;
                        state <= nine_q ? TS_BIT8 : TS_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TS_BIT8: begin
                    state <= TS_STOP;
                end
                TS_BRK: begin
                    if (cnt == CNT_W'(BRK_EXTRA - 1)) begin
                        cnt   <= '0;
                        state <= TS_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= TS_IDLE;
            endcase
        end
    end

    p_idle_line_high_r6: assert property (@(posedge clk) disable iff (rst)
        idle |-> line);

    p_disable_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> idle);

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(state));

    p_break_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (state == TS_BRK) |-> (cnt < CNT_W'(BRK_EXTRA)));

    p_load_only_when_free_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (state == TS_START));

endmodule

// File: rtl/utx_top.sv
module utx_top
    import utx_pkg::*;
#(
    parameter int BRK_EXTRA = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic              tx_en,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_bit8,
    input  logic              wr_nine,
    input  logic              wr_brk,
    output logic              txd,
    output logic              hold_empty,
    output logic              shift_idle
);

    utx_hold_t wr_entry;
    utx_hold_t hold_q;
    logic      hold_valid;
    logic      take;
    logic      run;

    always_comb begin
        wr_entry.brk  = wr_brk;
        wr_entry.nine = wr_nine;
        wr_entry.bit8 = wr_bit8;
        wr_entry.data = wr_data;
        run           = mod_en && tx_en;
        hold_empty    = !hold_valid;
    end

    utx_hold_buf u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_entry (wr_entry),
        .take     (take),
        .valid    (hold_valid),
        .entry    (hold_q)
    );

    utx_shifter #(.BRK_EXTRA(BRK_EXTRA)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (bit_tick),
        .hold_valid (hold_valid),
        .hold_entry (hold_q),
        .take       (take),
        .line       (txd),
        .idle       (shift_idle)
    );

    p_disabled_line_high_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> txd);

endmodule

// File: tb/tb_utx_top.sv
module tb_utx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_en = 1'b0, tx_en = 1'b0, bit_tick = 1'b0;
    logic       wr_stb = 1'b0, wr_bit8 = 1'b0, wr_nine = 1'b0, wr_brk = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, hold_empty, shift_idle;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    tick_per = 4;
    int    tick_cnt = 0;
    bit    started = 1'b0;

    always #2.5 clk = ~clk;

    utx_top dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .tx_en(tx_en), .bit_tick(bit_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit8(wr_bit8), .wr_nine(wr_nine),
        .wr_brk(wr_brk), .txd(txd), .hold_empty(hold_empty), .shift_idle(shift_idle)
    );

    // Reference model: holding slot plus a queue of the frame bits still to send.
    bit       m_hv;
    bit [7:0] m_hd;
    bit       m_h8, m_hn, m_hb;
    bit       fq[$];

    always @(posedge clk) begin
        bit old_hv;
        started <= 1'b1;
        if (rst) begin
            m_hv = 0;
            fq.delete();
        end else begin
            old_hv = m_hv;
            if (!(mod_en && tx_en)) begin
                fq.delete();
            end else if (bit_tick) begin
                if (fq.size() <= 1 && m_hv) begin
                    fq.delete();
                    fq.push_back(1'b0);
                    if (m_hb) begin
                        for (int i = 0; i < 12; i++) fq.push_back(1'b0);
                    end else begin
                        for (int i = 0; i < 8; i++) fq.push_back(m_hd[i]);
                        if (m_hn) fq.push_back(m_h8);
                    end
                    fq.push_back(1'b1);
                    m_hv = 0;
                end else if (fq.size() > 0) begin
                    void'(fq.pop_front());
                end
            end
            if (wr_stb && !old_hv) begin
                m_hv = 1; m_hd = wr_data; m_h8 = wr_bit8; m_hn = wr_nine; m_hb = wr_brk;
            end
        end
    end

    // Tick generator, driven on the falling edge.
    always @(negedge clk) begin
        if (tick_cnt >= tick_per - 1) begin
            tick_cnt <= 0;
            bit_tick <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1;
            bit_tick <= 1'b0;
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        bit e_line, e_empty, e_idle;
        if (started) begin
            e_line  = (fq.size() > 0) ? fq[0] : 1'b1;
            e_empty = !m_hv;
            e_idle  = (fq.size() == 0);
            checks++;
            if (txd !== e_line) begin
                errors++;
                $display("FAIL %s txd act=%b exp=%b t=%0t", cur_req, txd, e_line, $time);
            end
            checks++;
            if (hold_empty !== e_empty) begin
                errors++;
                $display("FAIL %s hold_empty act=%b exp=%b t=%0t", cur_req, hold_empty, e_empty, $time);
            end
            checks++;
            if (shift_idle !== e_idle) begin
                errors++;
                $display("FAIL %s shift_idle act=%b exp=%b t=%0t", cur_req, shift_idle, e_idle, $time);
            end
        end
    end

    task automatic put(input logic [7:0] d, input logic b8, input logic n9, input logic bk);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; wr_bit8 = b8; wr_nine = n9; wr_brk = bk;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_cycles(3);
        // R1: reset values, checked directly as well
        checks++;
        if (txd !== 1'b1 || hold_empty !== 1'b1 || shift_idle !== 1'b1) begin
            errors++;
            $display("FAIL R1 act=%b%b%b exp=111", txd, hold_empty, shift_idle);
        end
        @(negedge clk); rst = 1'b0;
        mod_en = 1'b1; tx_en = 1'b1;

        cur_req = "R3";                       // plain 8-bit character
        put(8'hA5, 1'b0, 1'b0, 1'b0);
        cur_req = "R2";                       // write while full is ignored
        put(8'h3C, 1'b1, 1'b1, 1'b1);
        idle_cycles(60);

        cur_req = "R4";                       // ninth bit both values
        put(8'h81, 1'b1, 1'b1, 1'b0);
        idle_cycles(60);
        put(8'h7E, 1'b0, 1'b1, 1'b0);
        idle_cycles(60);

        cur_req = "R5";                       // break, data inputs set but unused
        put(8'hFF, 1'b1, 1'b1, 1'b1);
        idle_cycles(80);

        cur_req = "R9";                       // back-to-back through the stop bit
        put(8'h55, 1'b0, 1'b0, 1'b0);
        idle_cycles(10);
        put(8'hC3, 1'b1, 1'b1, 1'b0);
        put(8'h11, 1'b0, 1'b0, 1'b0);         // ignored while full
        idle_cycles(100);

        cur_req = "R8";                       // disable mid-frame with a waiting char
        put(8'h96, 1'b0, 1'b0, 1'b0);
        idle_cycles(14);
        put(8'h69, 1'b0, 1'b0, 1'b0);
        tx_en = 1'b0;
        idle_cycles(30);
        tx_en = 1'b1;
        idle_cycles(8);
        mod_en = 1'b0;
        idle_cycles(12);
        mod_en = 1'b1;
        idle_cycles(70);

        cur_req = "R7";                       // tick of one cycle and mixed traffic
        tick_per = 1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            wr_stb  = ($urandom_range(0, 3) == 0);
            wr_data = 8'($urandom);
            wr_bit8 = 1'($urandom);
            wr_nine = 1'($urandom);
            wr_brk  = ($urandom_range(0, 7) == 0);
            tx_en   = ($urandom_range(0, 31) != 0);
        end
        wr_stb = 1'b0; tx_en = 1'b1;
        tick_per = 3;
        cur_req = "R6";
        idle_cycles(120);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule